// File: doc/BRIEF.md
# I2C Counted Burst Receiver

This block is the receive engine of an I2C master. A single control write arms a burst. That write carries a byte count and a flag that asks for a NAK on the final byte. The engine then generates SCL, shifts in that many bytes MSB first and answers each one on the ninth clock. It drives SDA low to acknowledge every byte except the last byte of a burst whose NAK flag is set; for that byte it releases SDA.

Received bytes go into an on-chip FIFO that the CPU drains one byte per pop. A status byte reports whether the FIFO is empty and whether the armed count has been reached. The completion flag can raise an interrupt when its enable is set. START, STOP and address phases belong to the surrounding controller. Transfers longer than the FIFO are split by software into several bursts, and only the final burst carries the NAK flag.

Top module: `i2c_rx_burst`

## Requirements
- R1: While idle, a control write whose count field (bits [6:0]) is between 1 and DEPTH starts a burst of exactly that many bytes. A write with count 0, a count above DEPTH, or any write made while a burst runs starts nothing and leaves the running burst unchanged.
- R2: Each bit period holds SCL low for HALF cycles and then high for HALF cycles. SDA is sampled on the rising SCL edge, MSB first. SCL rests low whenever no burst runs.
- R3: During the ninth clock of each byte, `sda_oe` is 1 (SDA pulled low, ACK). The exception is the last byte of a burst armed with control bit 7 set: there `sda_oe` is 0 (NAK).
- R4: Bytes are stored in arrival order. `pop_data` shows the oldest stored byte, and a cycle with `pop` high removes it.
- R5: A pop while the FIFO is empty returns `pop_data` = 0 and changes nothing.
- R6: `rd_status` bit 2 is 1 exactly when the FIFO holds no byte.
- R7: `rd_status` bit 4 (done) is set in the cycle the final byte of a burst is stored. It is cleared by `done_clr` or by a new launch. `irq` equals done AND `done_ie`.
- R8: A byte that completes while the FIFO is full is dropped, and the bytes already stored are kept.
- R9: After reset the block is idle: SCL low, `sda_oe` 0, `rd_status` = 8'h04, `irq` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control value: [6:0] count, [7] NAK on last byte |
| done_clr | input | 1 | Clears the done flag |
| done_ie | input | 1 | Interrupt enable for done |
| pop | input | 1 | Removes the oldest FIFO byte |
| pop_data | output | 8 | Oldest FIFO byte, 0 when empty |
| rd_status | output | 8 | Bit 4 done, bit 2 FIFO empty, others 0 |
| irq | output | 1 | Done interrupt |
| scl_o | output | 1 | Serial clock |
| sda_i | input | 1 | Serial data from target |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench builds the block with DEPTH = 8 and HALF = 2. Each byte then takes 36 cycles, so a burst that fills the whole FIFO takes only a few hundred cycles. With the FIFO this shallow, a second burst landing on a full FIFO is cheap to produce, and so is a count just above DEPTH. This makes the drop-on-full and reject-oversized-count paths reachable alongside the normal ACK/NAK bursts from the vector table.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int CTL_NAK_BIT    = 7;
  localparam int CTL_CNT_MSB    = 6;
  localparam int STAT_EMPTY_BIT = 2;
  localparam int STAT_DONE_BIT  = 4;
  localparam int BYTE_W         = 8;
  localparam int ACK_SLOT       = BYTE_W;
endpackage

// File: rtl/i2c_rx_fifo.sv
module i2c_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 pop_data,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          full, do_push, do_pop;

  assign empty    = (lvl_q == '0);
  assign full     = (lvl_q == LW'(DEPTH));
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign pop_data = empty ? '0 : mem[rd_q];
  assign level    = lvl_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + AW'(1);
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + AW'(1);
    if (do_push && !do_pop) lvl_d = lvl_q + LW'(1);
    if (do_pop && !do_push) lvl_d = lvl_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end
endmodule

// File: rtl/i2c_rx_bitclk.sv
module i2c_rx_bitclk
  import i2c_rx_pkg::*;
#(
  parameter int HALF = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              sda_i,
  input  logic              ack_en,
  output logic              scl_o,
  output logic              sda_oe,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0]     hcnt_q, hcnt_d;
  logic              scl_q, scl_d;
  logic [3:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              phase_end, in_ack;

  assign phase_end = run && (hcnt_q == HW'(HALF-1));
  assign in_ack    = (bit_q == 4'(ACK_SLOT));
  assign byte_done = phase_end && scl_q && in_ack;
  assign byte_data = sh_q;
  assign scl_o     = scl_q;
  assign sda_oe    = run && in_ack && ack_en;

  always_comb begin
    hcnt_d = hcnt_q;
    scl_d  = scl_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    if (!run) begin
      hcnt_d = '0;
      scl_d  = 1'b0;
      bit_d  = '0;
    end else if (phase_end) begin
      hcnt_d = '0;
      scl_d  = !scl_q;
      if (!scl_q && !in_ack) sh_d = {sh_q[BYTE_W-2:0], sda_i};
      if (scl_q) bit_d = in_ack ? 4'd0 : bit_q + 4'd1;
    end else begin
      hcnt_d = hcnt_q + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      scl_q  <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      hcnt_q <= hcnt_d;
      scl_q  <= scl_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
    end
  end
endmodule

// File: rtl/i2c_rx_burst.sv
module i2c_rx_burst
  import i2c_rx_pkg::*;
#(
  parameter int DEPTH = 64,  // at most 127: the count field is 7 bits
  parameter int HALF  = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       done_clr,
  input  logic       done_ie,
  input  logic       pop,
  output logic [7:0] pop_data,
  output logic [7:0] rd_status,
  output logic       irq,
  output logic       scl_o,
  input  logic       sda_i,
  output logic       sda_oe
);
  localparam int CW = $clog2(DEPTH+1);

  logic [1:0]              rst_sync;
  logic                    rst_s_n;
  logic                    busy_q, busy_d, nak_q, nak_d, done_q, done_d;
  logic [CW-1:0]           remain_q, remain_d;
  logic [CTL_CNT_MSB:0]    fld;
  logic                    fld_ok, launch, last, ack_en;
  logic                    byte_done, fifo_empty;
  logic [BYTE_W-1:0]       byte_data;
  logic [CW-1:0]           level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  assign fld    = ctl_wdata[CTL_CNT_MSB:0];
  assign fld_ok = (fld != '0) && (fld <= 7'(DEPTH));
  assign launch = ctl_wr && !busy_q && fld_ok;
  assign last   = (remain_q == CW'(1));
  assign ack_en = !(nak_q && last);

  always_comb begin
    busy_d   = busy_q;
    nak_d    = nak_q;
    remain_d = remain_q;
    done_d   = done_q;
    if (done_clr) done_d = 1'b0;
    if (launch) begin
      busy_d   = 1'b1;
      nak_d    = ctl_wdata[CTL_NAK_BIT];
      remain_d = CW'(fld);
      done_d   = 1'b0;
    end else if (byte_done) begin
      remain_d = remain_q - CW'(1);
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      busy_q   <= 1'b0;
      nak_q    <= 1'b0;
      remain_q <= '0;
      done_q   <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      nak_q    <= nak_d;
      remain_q <= remain_d;
      done_q   <= done_d;
    end
  end

  i2c_rx_bitclk #(.HALF(HALF)) u_bits (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .run       (busy_q),
    .sda_i     (sda_i),
    .ack_en    (ack_en),
    .scl_o     (scl_o),
    .sda_oe    (sda_oe),
    .byte_done (byte_done),
    .byte_data (byte_data)
  );

  i2c_rx_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .push      (byte_done),
    .push_data (byte_data),
    .pop       (pop),
    .pop_data  (pop_data),
    .empty     (fifo_empty),
    .level     (level)
  );

  always_comb begin
    rd_status                 = '0;
    rd_status[STAT_EMPTY_BIT] = fifo_empty;
    rd_status[STAT_DONE_BIT]  = done_q;
  end
  assign irq = done_q && done_ie;
endmodule

// File: rtl/i2c_rx_burst_chk.sv
module i2c_rx_burst_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic [CW-1:0] remain,
  input logic          done,
  input logic          irq,
  input logic          empty,
  input logic [CW-1:0] level,
  input logic          pop,
  input logic          push,
  input logic [7:0]    pop_data,
  input logic          sda_oe,
  input logic          scl_o
);
  assert_count_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> remain != '0);
  assert_idle_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scl_o);
  assert_ack_in_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> busy);
  assert_empty_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |-> pop_data == 8'h00);
  assert_empty_pop_inert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> level == '0);
  assert_empty_matches_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (level == '0));
  assert_done_after_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy);
  assert_irq_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
endmodule

bind i2c_rx_burst i2c_rx_burst_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .busy     (busy_q),
  .remain   (remain_q),
  .done     (done_q),
  .irq      (irq),
  .empty    (fifo_empty),
  .level    (level),
  .pop      (pop),
  .push     (byte_done),
  .pop_data (pop_data),
  .sda_oe   (sda_oe),
  .scl_o    (scl_o)
);

// File: tb/i2c_rx_burst_test.sv
module i2c_rx_burst_test;
  localparam int DEPTH = 8;
  localparam int HALF  = 2;
  // {nak, count[6:0], seed[7:0]}
  localparam logic [15:0] VEC [5] = '{16'h81A5, 16'h033C, 16'h8800, 16'h01FF, 16'h8581};

  logic       clk = 1'b0;
  logic       rst_n, ctl_wr, done_clr, done_ie, pop, sda_i;
  logic [7:0] ctl_wdata, pop_data, rd_status;
  logic       irq, scl_o, sda_oe;
  int         nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  i2c_rx_burst #(.DEPTH(DEPTH), .HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .done_clr(done_clr), .done_ie(done_ie), .pop(pop), .pop_data(pop_data),
    .rd_status(rd_status), .irq(irq), .scl_o(scl_o), .sda_i(sda_i), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] tb_byte(logic [7:0] s, int k);
    return (s + 8'(k * 71)) ^ 8'(k);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_write(logic [7:0] v);
    ctl_wdata = v; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic pop_one(output logic [7:0] v);
    v = pop_data; pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  // Acts as the target: serves bytes, records ACK/NAK and the first high phase.
  task automatic run_burst(int cnt, bit nak, logic [7:0] seed, bit inject);
    int ack_bad = 0, hi0 = -1;
    ctl_write({nak, 7'(cnt)});
    check(rd_status[4] == 1'b0, "R7 launch clears done", rd_status[4], 0);
    for (int k = 0; k < cnt; k++) begin
      logic [7:0] b = tb_byte(seed, k);
      for (int i = 0; i < 9; i++) begin
        int hi = 0;
        sda_i = (i < 8) ? b[7-i] : 1'b1;
        if (inject && k == 0 && i == 3) ctl_write(8'h05);
        while (scl_o !== 1'b1) @(negedge clk);
        if (i == 8 && sda_oe !== !(nak && k == cnt - 1)) ack_bad++;
        while (scl_o === 1'b1) begin hi++; @(negedge clk); end
        if (k == 0 && i == 0) hi0 = hi;
      end
    end
    check(hi0 == HALF, "R2 SCL high phase", hi0, HALF);
    check(ack_bad == 0, "R3 ACK/NAK per byte", ack_bad, 0);
    check(rd_status[4] == 1'b1, "R7 done after last byte", rd_status[4], 1);
  endtask

  task automatic drain_check(int cnt, logic [7:0] seed, string req);
    int bad = 0;
    logic [7:0] v;
    for (int k = 0; k < cnt; k++) begin
      pop_one(v);
      if (v !== tb_byte(seed, k)) bad++;
    end
    check(bad == 0, req, bad, 0);
    check(rd_status[2] == 1'b1, "R6 empty after drain", rd_status[2], 1);
  endtask

  task automatic idle_watch(logic [7:0] v, string req);
    int moved = 0;
    ctl_write(v);
    for (int c = 0; c < 30; c++) begin
      if (scl_o !== 1'b0 || sda_oe !== 1'b0) moved++;
      @(negedge clk);
    end
    check(moved == 0 && rd_status == 8'h04, req, {moved[7:0], rd_status}, 16'h0004);
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; done_clr = 1'b0;
    done_ie = 1'b0; pop = 1'b0; sda_i = 1'b1;
    #23 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    check(rd_status == 8'h04, "R9 reset status", rd_status, 8'h04);
    check(scl_o == 1'b0 && sda_oe == 1'b0 && irq == 1'b0, "R9 reset pins",
          {scl_o, sda_oe, irq}, 0);

    // R5 pop on empty
    check(pop_data == 8'h00, "R5 empty pop data", pop_data, 0);
    pop_one(v);
    check(rd_status[2] == 1'b1 && pop_data == 8'h00, "R5 empty pop inert",
          {rd_status[2], pop_data}, 9'h100);

    // Vector table: bursts with ACK/NAK variants, FIFO order R4
    foreach (VEC[n]) begin
      run_burst(int'(VEC[n][14:8]), VEC[n][15], VEC[n][7:0], 1'b0);
      check(rd_status[2] == 1'b0, "R6 not empty after burst", rd_status[2], 0);
      drain_check(int'(VEC[n][14:8]), VEC[n][7:0], "R4 FIFO order");
    end

    // R7 interrupt gating and clear
    check(irq == 1'b0, "R7 irq masked", irq, 0);
    done_ie = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R7 irq enabled", irq, 1);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    check(rd_status[4] == 1'b0 && irq == 1'b0, "R7 done_clr", {rd_status[4], irq}, 0);
    done_ie = 1'b0;

    // R1 zero count and oversize count start nothing
    idle_watch(8'h80, "R1 zero count ignored");
    idle_watch(8'(DEPTH + 1), "R1 oversize count ignored");

    // R1 write during a burst is ignored: exactly two bytes arrive
    run_burst(2, 1'b1, 8'h5A, 1'b1);
    repeat (40) @(negedge clk);
    check(scl_o == 1'b0, "R1 no burst from busy write", scl_o, 0);
    drain_check(2, 8'h5A, "R1 only armed bytes stored");

    // R8 full FIFO drops new bytes
    run_burst(DEPTH, 1'b0, 8'h11, 1'b0);
    run_burst(3, 1'b1, 8'hC7, 1'b0);
    drain_check(DEPTH, 8'h11, "R8 original bytes kept");

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule